// File: doc/BRIEF.md
# Multi-Master Two-Wire Bus Controller

This block is a byte-level controller that leads transfers on a shared I2C bus. The bus is open-drain, so the block drives its clock line and its data line only through pull-low enables. It reads both lines back through synchronizers. Software or a sequencer sends it commands one at a time on a valid/ready command stream. The commands are: take the bus (START), release it (STOP), shift a byte out, and shift a byte in with a chosen acknowledge. For each command the block returns exactly one response on a valid/ready response stream. The response carries the byte that was read, the acknowledge bit, and an error flag.

Each bit follows the bus level, not an internal timer. After the block releases the clock it waits until it sees the line high. It then counts the minimum high time from that observed rising edge. A slave that stretches the clock, or a slower master, therefore only slows the transfer down. Whenever the block leaves the data line released to send a one, it compares the line with that one. If the line is low, the block has lost arbitration. It releases both lines at once and reports the loss. It then refuses further commands until it sees a STOP on the bus. A bus monitor tracks START and STOP conditions from all masters, and the block will not open a transfer while another master holds the bus.

Flow control: a command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while no command is being executed and no response is waiting. A response is presented with `rsp_valid` and stays unchanged until the edge where `rsp_ready` is high. The next command is taken only after that.

Top module: `i2c_mm_master`

## Requirements
- R1: Both line outputs are pull-low enables (1 = pull low, 0 = release). After reset both are 0, `cmd_ready` is 1, and `rsp_valid`, `bus_busy` and `arb_lost` are 0. The block never holds a line while the bus is free and no command is running.
- R2: A START command (`cmd_op` = 0) that arrives while another master holds the bus is accepted but leaves both enables at 0. The START is carried out only after a STOP is seen on the bus.
- R3: On a free bus, START pulls the data line low while the clock line is released, then pulls the clock low. The response has `rsp_err` = 0 and `bus_busy` = 1.
- R4: WRITE (`cmd_op` = 2) sends `cmd_data` MSB first, changing the data line only while the clock is low. It then releases the data line for a ninth clock and reports `rsp_ack` = 1 if that bit was low and 0 if it was high.
- R5: READ (`cmd_op` = 3) releases the data line for 8 clocks and returns the sampled bits MSB first on `rsp_data`. On the ninth clock it pulls the line low (ACK, `rsp_ack` = 1) when `cmd_last` = 0, and leaves it released (NACK, `rsp_ack` = 0) when `cmd_last` = 1.
- R6: After releasing the clock, the block waits for as long as the clock line is held low by others. It then keeps the clock released for at least the configured high count, counted from the observed rising edge.
- R7: STOP (`cmd_op` = 1) pulls the data line low, releases the clock, then releases the data line, after which `bus_busy` is 0. A START while the block already owns the bus makes a repeated START: data line released, clock released, data line pulled low. No STOP comes between the two, and `bus_busy` stays 1.
- R8: If the block sees the data line low while it is sending a one, it sets `arb_lost`, releases both lines in that same cycle, and answers the command with `rsp_err` = 1.
- R9: While `arb_lost` is 1, every command is answered with `rsp_err` = 1 and causes no line activity. `arb_lost` returns to 0 when a STOP is seen on the bus.
- R10: WRITE, READ or STOP given while the block does not own the bus is answered with `rsp_err` = 1 and causes no line activity.
- R11: The response fields stay stable while `rsp_valid` is 1 and `rsp_ready` is 0. `cmd_ready` falls after each accepted command.
- R12: `speed_fast` = 1 selects the fast low and high counts and 0 selects the standard counts. The setting is sampled at the start of each bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_fast | input | 1 | 1 = fast-mode bit timing, 0 = standard-mode bit timing |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can take a command |
| cmd_op | input | 2 | 0 START, 1 STOP, 2 WRITE, 3 READ |
| cmd_data | input | 8 | Byte to write |
| cmd_last | input | 1 | READ only: 1 = answer with NACK |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_data | output | 8 | Byte read (0 for other commands) |
| rsp_ack | output | 1 | Acknowledge seen (WRITE) or sent (READ) |
| rsp_err | output | 1 | Command refused or arbitration lost |
| bus_busy | output | 1 | A START has been seen on the bus without a STOP after it |
| arb_lost | output | 1 | Arbitration lost, no STOP seen since |
| scl_i | input | 1 | Clock line level |
| sda_i | input | 1 | Data line level |
| scl_oe | output | 1 | Pull clock line low |
| sda_oe | output | 1 | Pull data line low |

## Verification
The bench acts as a slave that holds the clock low well past the block's own low time before the acknowledge clock. It then measures the high pulse that follows. A block that counts its high time from the moment it releases the clock, instead of from the observed rise, would produce a pulse that is far too short there. A second master is played by the bench: it pulls the data line low under a one the block is sending, and it holds the bus before a START. A block that keeps driving after the loss, or that clears the loss before the STOP, or that begins its START on a busy bus, shows up as line activity or wrong flags at those points. Random bytes, acknowledge choices, repeated STARTs and both speeds are checked against the shifted data and the measured low-phase lengths.

// File: rtl/i2c_mm_pkg.sv
package i2c_mm_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    BK_START  = 2'd0,
    BK_RSTART = 2'd1,
    BK_DATA   = 2'd2,
    BK_STOP   = 2'd3
  } bitkind_e;
endpackage

// File: rtl/i2c_mm_sync.sv
module i2c_mm_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '1;
      else if (g == 0) stage_q[g] <= d;
      else stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/i2c_mm_watch.sv
module i2c_mm_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic busy,
  output logic stop_seen
);
  logic scl_d, sda_d, start_seen;

  assign start_seen = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_seen  = scl_s & scl_d & ~sda_d & sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
      busy  <= 1'b0;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
      if (start_seen) busy <= 1'b1;
      else if (stop_seen) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_mm_bit.sv
module i2c_mm_bit
  import i2c_mm_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  bitkind_e      kind,
  input  logic          tx,
  input  logic          chk,
  input  logic [CW-1:0] low_cyc,
  input  logic [CW-1:0] high_cyc,
  input  logic [CW-1:0] hold_cyc,
  input  logic          scl_s,
  input  logic          sda_s,
  output logic          done,
  output logic          rx,
  output logic          arb,
  output logic          scl_oe,
  output logic          sda_oe
);
  typedef enum logic [2:0] {B_IDLE, B_LOW, B_RISE, B_HIGH, B_TAIL} bstate_e;

  bstate_e       st;
  bitkind_e      kind_q;
  logic          tx_q, chk_q;
  logic [CW-1:0] cnt, low_q, high_q, hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= B_IDLE;
      kind_q <= BK_START;
      tx_q   <= 1'b1;
      chk_q  <= 1'b0;
      cnt    <= '0;
      low_q  <= '0;
      high_q <= '0;
      hold_q <= '0;
      done   <= 1'b0;
      arb    <= 1'b0;
      rx     <= 1'b1;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      done <= 1'b0;
      arb  <= 1'b0;
      case (st)
        B_IDLE: if (go) begin
          kind_q <= kind;
          tx_q   <= tx;
          chk_q  <= chk;
          low_q  <= low_cyc;
          high_q <= high_cyc;
          hold_q <= hold_cyc;
          cnt    <= '0;
          if (kind == BK_START) begin
            sda_oe <= 1'b1;
            st     <= B_HIGH;
          end else begin
            st <= B_LOW;
          end
        end
        B_LOW: begin
          cnt <= cnt + 1'b1;
          if (cnt == hold_q) begin
            case (kind_q)
              BK_DATA:   sda_oe <= ~tx_q;
              BK_STOP:   sda_oe <= 1'b1;
              BK_RSTART: sda_oe <= 1'b0;
              default:   sda_oe <= sda_oe;
            endcase
          end
          if (cnt == low_q) begin
            scl_oe <= 1'b0;
            st     <= B_RISE;
          end
        end
        B_RISE: if (scl_s) begin
          cnt <= '0;
          st  <= B_HIGH;
        end
        B_HIGH: begin
          cnt <= cnt + 1'b1;
          if (cnt == high_q) begin
            case (kind_q)
              BK_START: begin
                scl_oe <= 1'b1;
                done   <= 1'b1;
                st     <= B_IDLE;
              end
              BK_DATA: begin
                rx <= sda_s;
                if (chk_q && tx_q && !sda_s) begin
                  scl_oe <= 1'b0;
                  sda_oe <= 1'b0;
                  arb    <= 1'b1;
                end else begin
                  scl_oe <= 1'b1;
                end
                done <= 1'b1;
                st   <= B_IDLE;
              end
              BK_STOP: begin
                sda_oe <= 1'b0;
                cnt    <= '0;
                st     <= B_TAIL;
              end
              default: begin
                if (!sda_s) begin
                  scl_oe <= 1'b0;
                  sda_oe <= 1'b0;
                  arb    <= 1'b1;
                  done   <= 1'b1;
                  st     <= B_IDLE;
                end else begin
                  sda_oe <= 1'b1;
                  cnt    <= '0;
                  st     <= B_TAIL;
                end
              end
            endcase
          end
        end
        B_TAIL: begin
          cnt <= cnt + 1'b1;
          if (cnt == high_q) begin
            if (kind_q == BK_RSTART) scl_oe <= 1'b1;
            done <= 1'b1;
            st   <= B_IDLE;
          end
        end
        default: st <= B_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_mm_master.sv
module i2c_mm_master
  import i2c_mm_pkg::*;
#(
  parameter int LOW_STD   = 250,
  parameter int HIGH_STD  = 200,
  parameter int LOW_FAST  = 70,
  parameter int HIGH_FAST = 35,
  parameter int HOLD_CYC  = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       speed_fast,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [1:0] cmd_op,
  input  logic [7:0] cmd_data,
  input  logic       cmd_last,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic [7:0] rsp_data,
  output logic       rsp_ack,
  output logic       rsp_err,
  output logic       bus_busy,
  output logic       arb_lost,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe
);
  localparam int MAX_LOW  = (LOW_STD > LOW_FAST) ? LOW_STD : LOW_FAST;
  localparam int MAX_HIGH = (HIGH_STD > HIGH_FAST) ? HIGH_STD : HIGH_FAST;
  localparam int MAXC     = (MAX_LOW > MAX_HIGH) ? MAX_LOW : MAX_HIGH;
  localparam int CW       = $clog2(MAXC + 1) + 1;

  typedef enum logic [1:0] {T_IDLE, T_WFREE, T_RUN, T_RSP} tstate_e;

  logic [1:0]    lines_s;
  logic          scl_s, sda_s, stop_seen;
  logic          b_done, b_rx, b_arb;
  logic [CW-1:0] low_sel, high_sel;

  tstate_e       st;
  op_e           op_q;
  bitkind_e      kind_q;
  logic          go_q, tx_q, chk_q, nack_q, own_q, arb_q;
  logic [7:0]    sh, rsp_data_q;
  logic [3:0]    bitn;
  logic          rsp_ack_q, rsp_err_q;

  i2c_mm_sync #(.W(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(lines_s)
  );
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  i2c_mm_watch u_watch (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .busy(bus_busy), .stop_seen(stop_seen)
  );

  assign low_sel  = speed_fast ? CW'(LOW_FAST)  : CW'(LOW_STD);
  assign high_sel = speed_fast ? CW'(HIGH_FAST) : CW'(HIGH_STD);

  i2c_mm_bit #(.CW(CW)) u_bit (
    .clk(clk), .rst_n(rst_n), .go(go_q), .kind(kind_q), .tx(tx_q), .chk(chk_q),
    .low_cyc(low_sel), .high_cyc(high_sel), .hold_cyc(CW'(HOLD_CYC)),
    .scl_s(scl_s), .sda_s(sda_s), .done(b_done), .rx(b_rx), .arb(b_arb),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  assign cmd_ready = (st == T_IDLE);
  assign rsp_valid = (st == T_RSP);
  assign rsp_data  = rsp_data_q;
  assign rsp_ack   = rsp_ack_q;
  assign rsp_err   = rsp_err_q;
  assign arb_lost  = arb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= T_IDLE;
      op_q       <= OP_START;
      kind_q     <= BK_START;
      go_q       <= 1'b0;
      tx_q       <= 1'b1;
      chk_q      <= 1'b0;
      nack_q     <= 1'b0;
      own_q      <= 1'b0;
      arb_q      <= 1'b0;
      sh         <= '0;
      bitn       <= '0;
      rsp_data_q <= '0;
      rsp_ack_q  <= 1'b0;
      rsp_err_q  <= 1'b0;
    end else begin
      go_q <= 1'b0;
      if (arb_q && stop_seen) arb_q <= 1'b0;
      case (st)
        T_IDLE: if (cmd_valid) begin
          op_q       <= op_e'(cmd_op);
          sh         <= cmd_data;
          nack_q     <= cmd_last;
          bitn       <= '0;
          rsp_data_q <= '0;
          rsp_ack_q  <= 1'b0;
          rsp_err_q  <= 1'b0;
          if (arb_q || (op_e'(cmd_op) != OP_START && !own_q)) begin
            rsp_err_q <= 1'b1;
            st        <= T_RSP;
          end else begin
            case (op_e'(cmd_op))
              OP_START: begin
                if (own_q) begin
                  go_q   <= 1'b1;
                  kind_q <= BK_RSTART;
                  st     <= T_RUN;
                end else begin
                  st <= T_WFREE;
                end
              end
              OP_STOP: begin
                go_q   <= 1'b1;
                kind_q <= BK_STOP;
                st     <= T_RUN;
              end
              default: begin
                go_q   <= 1'b1;
                kind_q <= BK_DATA;
                tx_q   <= (op_e'(cmd_op) == OP_WRITE) ? cmd_data[7] : 1'b1;
                chk_q  <= (op_e'(cmd_op) == OP_WRITE);
                st     <= T_RUN;
              end
            endcase
          end
        end
        T_WFREE: if (!bus_busy) begin
          go_q   <= 1'b1;
          kind_q <= BK_START;
          st     <= T_RUN;
        end
        T_RUN: if (b_done) begin
          if (b_arb) begin
            arb_q     <= 1'b1;
            own_q     <= 1'b0;
            rsp_err_q <= 1'b1;
            st        <= T_RSP;
          end else begin
            case (op_q)
              OP_START: begin
                own_q <= 1'b1;
                st    <= T_RSP;
              end
              OP_STOP: begin
                own_q <= 1'b0;
                st    <= T_RSP;
              end
              default: begin
                if (bitn == 4'd8) begin
                  rsp_ack_q <= (op_q == OP_WRITE) ? ~b_rx : ~nack_q;
                  st        <= T_RSP;
                end else begin
                  sh     <= {sh[6:0], b_rx};
                  bitn   <= bitn + 1'b1;
                  go_q   <= 1'b1;
                  kind_q <= BK_DATA;
                  if (bitn == 4'd7) begin
                    tx_q  <= (op_q == OP_WRITE) ? 1'b1 : nack_q;
                    chk_q <= (op_q == OP_READ) && nack_q;
                    if (op_q == OP_READ) rsp_data_q <= {sh[6:0], b_rx};
                  end else begin
                    tx_q  <= (op_q == OP_WRITE) ? sh[6] : 1'b1;
                    chk_q <= (op_q == OP_WRITE);
                  end
                end
              end
            endcase
          end
        end
        T_RSP: if (rsp_ready) st <= T_IDLE;
        default: st <= T_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_mm_master_chk.sv
module i2c_mm_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_data,
  input logic       rsp_ack,
  input logic       rsp_err,
  input logic       bus_busy,
  input logic       arb_lost,
  input logic       scl_oe,
  input logic       sda_oe
);
  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_ack) && $stable(rsp_err));

  // R11
  cmd_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_ready);

  // R8
  arb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost) |-> !scl_oe && !sda_oe && rsp_valid && rsp_err);

  // R9
  arb_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> !scl_oe && !sda_oe);

  // R9
  arb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(arb_lost) |-> !bus_busy);

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_busy && cmd_ready |-> !scl_oe && !sda_oe);
endmodule

bind i2c_mm_master i2c_mm_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .rsp_ack(rsp_ack), .rsp_err(rsp_err), .bus_busy(bus_busy),
  .arb_lost(arb_lost), .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/i2c_mm_master_bench.sv
module i2c_mm_master_bench;
  localparam int LOW_STD = 40, HIGH_STD = 32, LOW_FAST = 14, HIGH_FAST = 9, HOLD_CYC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       speed_fast = 1'b0;
  logic       cmd_valid = 1'b0, cmd_last = 1'b0, rsp_ready = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] cmd_data = 8'd0;
  logic       cmd_ready, rsp_valid, rsp_ack, rsp_err, bus_busy, arb_lost;
  logic [7:0] rsp_data;
  logic       scl_oe, sda_oe;
  logic       s_scl_low = 1'b0, s_sda_low = 1'b0;
  logic       scl_line, sda_line;

  assign scl_line = ~(scl_oe | s_scl_low);
  assign sda_line = ~(sda_oe | s_sda_low);

  i2c_mm_master #(.LOW_STD(LOW_STD), .HIGH_STD(HIGH_STD), .LOW_FAST(LOW_FAST),
                  .HIGH_FAST(HIGH_FAST), .HOLD_CYC(HOLD_CYC)) u_i2c_mm_master (
    .clk(clk), .rst_n(rst_n), .speed_fast(speed_fast),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_last(cmd_last),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_ack(rsp_ack), .rsp_err(rsp_err), .bus_busy(bus_busy), .arb_lost(arb_lost),
    .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  int n_run = 0, n_fail = 0;
  int start_cnt = 0, stop_cnt = 0, oe_tog = 0;
  int lo_run = 0, lo_min = 1000000;
  logic [1:0] oe_prev = 2'b00;

  always @(negedge sda_line) if (rst_n && scl_line === 1'b1) start_cnt++;
  always @(posedge sda_line) if (rst_n && scl_line === 1'b1) stop_cnt++;
  always @(posedge clk) begin
    if (rst_n) begin
      if ({scl_oe, sda_oe} !== oe_prev) oe_tog++;
      oe_prev = {scl_oe, sda_oe};
      if (!scl_line) lo_run++;
      else begin
        if (lo_run > 0 && lo_run < lo_min) lo_min = lo_run;
        lo_run = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int low_of(input logic fast);
    return fast ? LOW_FAST : LOW_STD;
  endfunction
  function automatic int high_of(input logic fast);
    return fast ? HIGH_FAST : HIGH_STD;
  endfunction
  function automatic logic exp_ack(input logic nack);
    return !nack;
  endfunction

  task automatic do_cmd(input logic [1:0] op, input logic [7:0] d, input logic last,
                        input int bp, output logic [7:0] rd, output logic ak, output logic er);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d; cmd_last = last;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    rd = rsp_data; ak = rsp_ack; er = rsp_err;
    repeat (bp) @(negedge clk);
    if (bp > 0)
      chk(rsp_valid && rsp_data == rd && rsp_ack == ak && rsp_err == er,
          "R11 response held", int'(rsp_data), int'(rd));
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic slave_write(input logic nack, input int stretch,
                             output logic [7:0] got, output int hiw);
    got = 8'd0;
    for (int i = 0; i < 8; i++) begin
      @(posedge scl_line);
      got = {got[6:0], sda_line};
    end
    @(negedge scl_line);
    s_sda_low = !nack;
    if (stretch > 0) begin
      s_scl_low = 1'b1;
      repeat (stretch + LOW_STD) @(posedge clk);
      s_scl_low = 1'b0;
    end
    @(posedge scl_line);
    hiw = 0;
    while (scl_line) begin
      @(posedge clk);
      hiw++;
    end
    s_sda_low = 1'b0;
  endtask

  task automatic slave_read(input logic [7:0] d, output logic mack);
    s_sda_low = !d[7];
    for (int i = 0; i < 8; i++) begin
      @(posedge scl_line);
      @(negedge scl_line);
      s_sda_low = (i < 7) ? !d[6-i] : 1'b0;
    end
    @(posedge scl_line);
    mack = sda_line;
    @(negedge scl_line);
  endtask

  task automatic bus_start(input string req);
    logic [7:0] rd; logic ak, er; int sc;
    sc = start_cnt;
    do_cmd(2'd0, 8'd0, 1'b0, 0, rd, ak, er);
    chk(er == 1'b0, req, int'(er), 0);
    chk(start_cnt == sc + 1 && bus_busy, req, start_cnt - sc, 1);
  endtask

  task automatic bus_stop;
    logic [7:0] rd; logic ak, er; int pc;
    pc = stop_cnt;
    do_cmd(2'd1, 8'd0, 1'b0, 0, rd, ak, er);
    repeat (4) @(negedge clk);
    chk(er == 1'b0 && stop_cnt == pc + 1, "R7 stop generated", stop_cnt - pc, 1);
    chk(!bus_busy && scl_line && sda_line, "R7 bus free after stop", int'(bus_busy), 0);
  endtask

  task automatic wr_byte(input logic [7:0] d, input logic nack, input int stretch, input int bp);
    logic [7:0] rd, got; logic ak, er; int hiw;
    fork
      do_cmd(2'd2, d, 1'b0, bp, rd, ak, er);
      slave_write(nack, stretch, got, hiw);
    join
    chk(got == d, "R4 write bits", int'(got), int'(d));
    chk(ak == exp_ack(nack) && er == 1'b0, "R4 ack report", int'(ak), int'(exp_ack(nack)));
    chk(hiw >= high_of(speed_fast), "R6 high time from observed rise", hiw, high_of(speed_fast));
  endtask

  task automatic rd_byte(input logic [7:0] d, input logic last, input int bp);
    logic [7:0] rd; logic ak, er, mack;
    fork
      do_cmd(2'd3, 8'd0, last, bp, rd, ak, er);
      slave_read(d, mack);
    join
    chk(rd == d && er == 1'b0, "R5 read data", int'(rd), int'(d));
    chk(mack == last && ak == exp_ack(last), "R5 master ack bit", int'(mack), int'(last));
  endtask

  logic done_all = 1'b0;

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_all) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd; logic ak, er; int tg, sc, bad;
    void'($urandom(32'h5eed1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(!scl_oe && !sda_oe && cmd_ready && !rsp_valid && !bus_busy && !arb_lost,
        "R1 reset state", int'({scl_oe, sda_oe, rsp_valid, bus_busy, arb_lost}), 0);

    // R10 commands without owning the bus
    tg = oe_tog;
    do_cmd(2'd2, 8'hA5, 1'b0, 0, rd, ak, er);
    chk(er == 1'b1 && oe_tog == tg, "R10 write without bus", int'(er), 1);
    do_cmd(2'd1, 8'h00, 1'b0, 3, rd, ak, er);
    chk(er == 1'b1 && oe_tog == tg, "R10 stop without bus", int'(er), 1);

    // directed: standard speed, stretched write, read with ACK then NACK
    speed_fast = 1'b0;
    lo_min = 1000000;
    bus_start("R3 start on free bus");
    wr_byte(8'hA0, 1'b0, 60, 2);
    rd_byte(8'h3C, 1'b0, 0);
    rd_byte(8'hC3, 1'b1, 1);
    chk(lo_min >= LOW_STD + 1 && lo_min <= LOW_STD + 6, "R12 standard low time", lo_min, LOW_STD + 3);
    bus_stop();

    // random transactions
    for (int t = 0; t < 10; t++) begin
      int nb; logic rdmode;
      speed_fast = 1'($urandom % 2);
      lo_min = 1000000;
      bus_start("R3 start random");
      wr_byte(8'($urandom), 1'($urandom % 2), (t % 3 == 1) ? int'($urandom % 40) + 1 : 0, int'($urandom % 3));
      if (t % 3 == 0) begin
        sc = start_cnt; tg = stop_cnt;
        do_cmd(2'd0, 8'd0, 1'b0, 0, rd, ak, er);
        chk(er == 1'b0 && start_cnt == sc + 1 && stop_cnt == tg && bus_busy,
            "R7 repeated start", start_cnt - sc, 1);
      end
      nb = 1 + int'($urandom % 3);
      rdmode = 1'($urandom % 2);
      for (int b = 0; b < nb; b++) begin
        if (rdmode) rd_byte(8'($urandom), (b == nb - 1), int'($urandom % 2));
        else wr_byte(8'($urandom), 1'($urandom % 2), 0, 0);
      end
      chk(lo_min >= low_of(speed_fast) + 1 && lo_min <= low_of(speed_fast) + 6,
          "R12 low time for speed", lo_min, low_of(speed_fast) + 3);
      bus_stop();
    end

    // R8 arbitration loss on a driven one
    speed_fast = 1'b1;
    bus_start("R3 start before arbitration");
    fork
      do_cmd(2'd2, 8'hC5, 1'b0, 0, rd, ak, er);
      begin
        @(posedge scl_line);
        s_sda_low = 1'b1;
      end
    join
    chk(er == 1'b1 && arb_lost, "R8 loss reported", int'(er), 1);
    chk(!scl_oe && !sda_oe, "R8 lines released", int'({scl_oe, sda_oe}), 0);

    // R9 commands refused until STOP
    tg = oe_tog;
    do_cmd(2'd2, 8'h11, 1'b0, 0, rd, ak, er);
    chk(er == 1'b1 && oe_tog == tg, "R9 write refused", int'(er), 1);
    do_cmd(2'd0, 8'h00, 1'b0, 0, rd, ak, er);
    chk(er == 1'b1 && oe_tog == tg && arb_lost, "R9 start refused", int'(er), 1);
    repeat (5) @(negedge clk);
    s_sda_low = 1'b0;
    repeat (8) @(negedge clk);
    chk(!arb_lost && !bus_busy, "R9 loss cleared by stop", int'(arb_lost), 0);

    // R2 start waits while another master holds the bus
    s_sda_low = 1'b1;
    repeat (8) @(negedge clk);
    chk(bus_busy, "R2 foreign start seen", int'(bus_busy), 1);
    bad = 0; sc = start_cnt;
    fork
      do_cmd(2'd0, 8'd0, 1'b0, 0, rd, ak, er);
      begin
        repeat (150) begin
          @(negedge clk);
          if (scl_oe || sda_oe || rsp_valid) bad++;
        end
        s_sda_low = 1'b0;
      end
    join
    chk(bad == 0, "R2 no activity while busy", bad, 0);
    chk(er == 1'b0 && bus_busy && start_cnt == sc + 1, "R2 start after stop", start_cnt - sc, 1);
    wr_byte(8'h5A, 1'b0, 0, 0);
    bus_stop();

    done_all = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule